// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block decides, clock by clock, when the high-side and low-side switches of a synchronous buck power stage are enabled. It uses constant on-time control. A new high-side pulse begins only when a feedback comparator reports that the output has dropped below its reference. The pulse then lasts for a cycle count supplied by an external integrator, which derives it from the input and output voltages. After every pulse a fixed minimum off-time must pass before another pulse can start. Break-before-make gaps are inserted on both switch transitions.

The low-side behaviour depends on the operating mode:
- Continuous mode keeps the low switch on until the next pulse, so the frequency stays constant.
- Pulse-skipping mode emulates a diode: the low switch opens as soon as the zero-cross comparator shows the inductor current turning negative.
- Ultrasonic mode adds a frequency floor to pulse-skipping. It forces a pulse if none has started within the floor period, which keeps the switching frequency above the audible band.
- Off mode, and a separate fault input, both pull the two drives low in the same cycle and clear every timer.

All timing is counted in clock cycles. The defaults assume a 100 MHz clock: a 400 ns minimum off-time (40 cycles), a 30 ns gap from low-side off to high-side on (3 cycles), a 10 ns gap from high-side off to low-side on (1 cycle), and a 40 us floor period (4000 cycles).

Top module: `cot_seq_top`

## Requirements
- R1: The `mode` input selects the operating mode with the encoding 0 = off, 1 = continuous, 2 = ultrasonic, 3 = pulse-skipping. In off mode both drives stay low and feedback requests start no pulse.
- R2: In an active mode, when the off-time has elapsed and a feedback request (`fb_below` = 1) is presented before a clock edge, the low drive is released at that edge. `hs_en` rises DT_LH edges later, that is DT_LH+1 edges after the request was presented. While `fb_below` is 0 in continuous or pulse-skipping mode, no pulse starts.
- R3: `hs_en` stays high for exactly `on_time` cycles. `on_time` is sampled at the edge where `hs_en` rises, and a value of 0 is treated as 1.
- R4: With `fb_below` held at 1, `hs_en` stays low for exactly MIN_OFF+DT_LH cycles between pulses, and never for fewer than MIN_OFF cycles.
- R5: `ls_en` falls exactly DT_LH cycles before `hs_en` rises.
- R6: `ls_en` rises exactly DT_HL cycles after `hs_en` falls, unless diode emulation has already opened it.
- R7: In pulse-skipping and ultrasonic modes, `ls_en` drops one edge after `zero_cross` = 1 is sampled. It stays low until the next high-side pulse has ended, even if `zero_cross` returns to 0.
- R8: In continuous mode `zero_cross` is ignored, and `ls_en` stays high from the end of one pulse until the next pulse starts.
- R9: In ultrasonic mode, when no feedback request arrives, consecutive rises of `hs_en` are exactly FLOOR cycles apart. A feedback request can start a pulse earlier. In pulse-skipping mode no pulse is ever forced.
- R10: While `fault_off` = 1 or the mode is off, both drives are low in the same cycle. All timers are cleared: after release, a request starts a pulse at once without waiting out the rest of the off-time. `ls_en` stays low until the first new pulse has ended.
- R11: `hs_en` and `ls_en` are never high together.
- R12: During and after reset both drives are low, and `ls_en` stays low until the first pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_below | input | 1 | Feedback comparator: output is below reference |
| zero_cross | input | 1 | Switch-node comparator: inductor current going negative |
| on_time | input | ON_W | High-side pulse length in clock cycles |
| mode | input | 2 | Operating mode, 0 off, 1 continuous, 2 ultrasonic, 3 pulse-skipping |
| fault_off | input | 1 | Forces both drives low and clears all timers |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bound checker enforces the following on every cycle:
- the two drives are never on together;
- the off and fault conditions force both drives low;
- each drive rises only after its break-before-make gap;
- every high-side rise follows at least the minimum off-time;
- in ultrasonic mode the high-side drive never goes a full floor period without a rise.

Only the bench scenarios can show the exact cycle counts and the mode-dependent low-side behaviour:
- the delay from request to rise, the pulse width and the off-time;
- diode emulation opening the low switch and keeping it open;
- continuous mode ignoring the zero-cross input;
- the forced period being exact;
- a fault clearing the off-time timer.

// File: rtl/cot_pkg.sv
// Shared types for the constant on-time sequencer.
// Assumes a 2-bit decoded mode from the analog mode detector.
package cot_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_CCM   = 2'd1,
        MODE_ULTRA = 2'd2,
        MODE_PFM   = 2'd3
    } cot_mode_e;

    typedef enum logic [1:0] {
        PH_REST  = 2'd0,
        PH_LDEAD = 2'd1,
        PH_HIGH  = 2'd2,
        PH_HDEAD = 2'd3
    } cot_phase_e;
endpackage

// File: rtl/cot_phase_fsm.sv
// Switching phase machine: rest, gap before high, high pulse, gap after high.
// Also holds the diode-emulation latch that keeps the low switch open.
// Assumes DT_LH >= 1 and DT_HL >= 1; start is only honoured in the rest phase.
module cot_phase_fsm #(
    parameter int ON_W  = 8,
    parameter int DT_LH = 3,
    parameter int DT_HL = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   kill,
    input  logic                   start,
    input  logic                   zc_enable,
    input  logic                   zero_cross,
    input  logic [ON_W-1:0]        on_time,
    output cot_pkg::cot_phase_e    phase,
    output logic                   diode_off,
    output logic                   high_enter,
    output logic                   high_exit
);
    import cot_pkg::*;

    localparam int DT_MAX = (DT_LH > DT_HL) ? DT_LH : DT_HL;
    localparam int DT_W   = $clog2(DT_MAX + 1);
    localparam int CNT_W  = (ON_W > DT_W) ? ON_W : DT_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] on_len_m1;

    // Pulse length minus one, with a zero request stretched to one cycle.
    assign on_len_m1 = (on_time == '0) ? '0 : CNT_W'(on_time - 1'b1);

    assign high_enter = (phase == PH_LDEAD) && (cnt == '0);
    assign high_exit  = (phase == PH_HIGH)  && (cnt == '0);

    // Phase sequencing and the low-side open latch.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            phase     <= PH_REST;
            cnt       <= '0;
            diode_off <= 1'b1;
        end else begin
            case (phase)
                PH_REST: begin
                    if (start) begin
                        phase <= PH_LDEAD;
                        cnt   <= CNT_W'(DT_LH - 1);
                    end else if (zc_enable && zero_cross) begin
                        diode_off <= 1'b1;
                    end
                end
                PH_LDEAD: begin
                    if (cnt == '0) begin
                        phase     <= PH_HIGH;
                        cnt       <= on_len_m1;
                        diode_off <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        phase <= PH_HDEAD;
                        cnt   <= CNT_W'(DT_HL - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase <= PH_REST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cot_off_timer.sv
// Minimum off-time timer, loaded when the high pulse ends.
// Assumes MIN_OFF >= 1; done is high whenever no off-time is pending.
module cot_off_timer #(
    parameter int MIN_OFF = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic load,
    output logic done
);
    localparam int W = $clog2(MIN_OFF + 1);

    logic [W-1:0] cnt;

    // Count down the remaining off-time.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(MIN_OFF - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/cot_floor_timer.sv
// Frequency floor timer: cycles since the last high-side rise.
// Flags expiry early enough that the forced pulse rises exactly FLOOR cycles
// after the previous one. Assumes FLOOR > DT_LH + 1.
module cot_floor_timer #(
    parameter int FLOOR = 4000,
    parameter int DT_LH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic restart,
    output logic expired
);
    localparam int W      = $clog2(FLOOR + 1);
    localparam int THRESH = FLOOR - DT_LH - 1;

    logic [W-1:0] cnt;

    // Saturating count of cycles since the last pulse began.
    always_ff @(posedge clk) begin
        if (!rst_n || kill || restart) begin
            cnt <= '0;
        end else if (cnt != W'(FLOOR)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= W'(THRESH));
endmodule

// File: rtl/cot_seq_top.sv
// Constant on-time sequencer top: mode decode, start decision, drive gating.
// Assumes comparator inputs are already synchronised to clk.
// Off mode or fault_off gates both drives combinationally.
module cot_seq_top #(
    parameter int ON_W    = 8,
    parameter int MIN_OFF = 40,
    parameter int DT_LH   = 3,
    parameter int DT_HL   = 1,
    parameter int FLOOR   = 4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fb_below,
    input  logic            zero_cross,
    input  logic [ON_W-1:0] on_time,
    input  logic [1:0]      mode,
    input  logic            fault_off,
    output logic            hs_en,
    output logic            ls_en
);
    import cot_pkg::*;

    cot_mode_e  mode_e;
    cot_phase_e phase;
    logic       kill;
    logic       zc_enable;
    logic       off_done;
    logic       floor_expired;
    logic       start;
    logic       diode_off;
    logic       high_enter;
    logic       high_exit;

    assign mode_e    = cot_mode_e'(mode);
    assign kill      = fault_off || (mode_e == MODE_OFF);
    assign zc_enable = (mode_e == MODE_PFM) || (mode_e == MODE_ULTRA);
    assign start     = off_done &&
                       (fb_below || ((mode_e == MODE_ULTRA) && floor_expired));

    cot_phase_fsm #(.ON_W(ON_W), .DT_LH(DT_LH), .DT_HL(DT_HL)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .kill       (kill),
        .start      (start),
        .zc_enable  (zc_enable),
        .zero_cross (zero_cross),
        .on_time    (on_time),
        .phase      (phase),
        .diode_off  (diode_off),
        .high_enter (high_enter),
        .high_exit  (high_exit)
    );

    cot_off_timer #(.MIN_OFF(MIN_OFF)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .kill  (kill),
        .load  (high_exit),
        .done  (off_done)
    );

    cot_floor_timer #(.FLOOR(FLOOR), .DT_LH(DT_LH)) u_floor (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill    (kill),
        .restart (high_enter),
        .expired (floor_expired)
    );

    assign hs_en = (phase == PH_HIGH) && !kill;
    assign ls_en = (phase == PH_REST) && !diode_off && !kill;
endmodule

// File: rtl/cot_seq_checker.sv
// Cycle-level checker for the sequencer, bound to cot_seq_top.
// Tracks low-run lengths of each drive with saturating counters.
module cot_seq_checker #(
    parameter int MIN_OFF = 40,
    parameter int DT_LH   = 3,
    parameter int DT_HL   = 1,
    parameter int FLOOR   = 4000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       fault_off,
    input logic       hs_en,
    input logic       ls_en
);
    localparam int SAT = FLOOR + MIN_OFF + DT_LH + DT_HL + 2;
    localparam int CW  = $clog2(SAT + 1);
    localparam logic [CW-1:0] SAT_V     = CW'(SAT);
    localparam logic [CW-1:0] MIN_OFF_V = CW'(MIN_OFF);
    localparam logic [CW-1:0] DT_LH_V   = CW'(DT_LH);
    localparam logic [CW-1:0] DT_HL_V   = CW'(DT_HL);
    localparam logic [CW-1:0] FLOOR_V   = CW'(FLOOR);

    logic          kill_seen;
    logic [CW-1:0] hs_low_cnt;
    logic [CW-1:0] ls_low_cnt;
    logic [CW-1:0] ultra_cnt;

    assign kill_seen = fault_off || (mode == 2'd0);

    // Cycles since the high drive was last sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n || kill_seen)   hs_low_cnt <= SAT_V;
        else if (hs_en)            hs_low_cnt <= '0;
        else if (hs_low_cnt != SAT_V) hs_low_cnt <= hs_low_cnt + 1'b1;
    end

    // Cycles since the low drive was last sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n)                ls_low_cnt <= SAT_V;
        else if (ls_en)            ls_low_cnt <= '0;
        else if (ls_low_cnt != SAT_V) ls_low_cnt <= ls_low_cnt + 1'b1;
    end

    // Cycles without a high pulse while continuously in ultrasonic mode.
    always_ff @(posedge clk) begin
        if (!rst_n || kill_seen || mode != 2'd2) ultra_cnt <= '0;
        else if (hs_en)                          ultra_cnt <= '0;
        else if (ultra_cnt != SAT_V)             ultra_cnt <= ultra_cnt + 1'b1;
    end

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    a_r10_kill_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        kill_seen |-> (!hs_en && !ls_en));

    a_r4_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (hs_low_cnt >= MIN_OFF_V));

    a_r5_gap_low_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (ls_low_cnt >= DT_LH_V));

    a_r6_gap_high_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> (hs_low_cnt >= DT_HL_V));

    a_r9_floor_period: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (ultra_cnt < FLOOR_V));
endmodule

bind cot_seq_top cot_seq_checker #(
    .MIN_OFF (MIN_OFF),
    .DT_LH   (DT_LH),
    .DT_HL   (DT_HL),
    .FLOOR   (FLOOR)
) i_cot_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .fault_off (fault_off),
    .hs_en     (hs_en),
    .ls_en     (ls_en)
);

// File: tb/test_cot_seq_top.sv
// Scenario bench for cot_seq_top: edge times are logged at falling clock
// edges and compared with cycle counts derived from the requirements.
module test_cot_seq_top;
    localparam int ON_W    = 8;
    localparam int MIN_OFF = 40;
    localparam int DT_LH   = 3;
    localparam int DT_HL   = 1;
    localparam int FLOOR   = 4000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            fb_below;
    logic            zero_cross;
    logic [ON_W-1:0] on_time;
    logic [1:0]      mode;
    logic            fault_off;
    logic            hs_en;
    logic            ls_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_hr = 0;
    int n_hf = 0;
    int t_hr = 0, t_hf = 0, t_lr = 0, t_lf = 0;
    int overlap = 0;
    logic hs_q = 1'b0, ls_q = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cot_seq_top #(.ON_W(ON_W), .MIN_OFF(MIN_OFF), .DT_LH(DT_LH),
                  .DT_HL(DT_HL), .FLOOR(FLOOR)) i_cot_seq_top (
        .clk(clk), .rst_n(rst_n), .fb_below(fb_below), .zero_cross(zero_cross),
        .on_time(on_time), .mode(mode), .fault_off(fault_off),
        .hs_en(hs_en), .ls_en(ls_en));

    // Edge log, sampled away from the rising clock edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (hs_en && !hs_q) begin t_hr = cyc; n_hr = n_hr + 1; end
        if (!hs_en && hs_q) begin t_hf = cyc; n_hf = n_hf + 1; end
        if (ls_en && !ls_q) t_lr = cyc;
        if (!ls_en && ls_q) t_lf = cyc;
        if (hs_en && ls_en) overlap = overlap + 1;
        hs_q = hs_en;
        ls_q = ls_en;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_rise();
        int k;
        k = n_hr;
        while (n_hr == k) step(1);
    endtask

    task automatic wait_fall();
        int k;
        k = n_hf;
        while (n_hf == k) step(1);
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s, r1, k, w;
        int vals [6] = '{1, 3, 7, 64, 255, 0};
        rst_n = 1'b0; fb_below = 1'b0; zero_cross = 1'b0;
        on_time = 8'd20; mode = 2'd1; fault_off = 1'b0;
        step(3);
        check(!hs_en && !ls_en, "R12 reset drives", {hs_en, ls_en}, 0);
        rst_n = 1'b1;
        step(5);
        check(!ls_en, "R12 low open before first pulse", ls_en, 0);

        // Continuous mode: request, width, gaps, off-time.
        s = cyc; fb_below = 1'b1;
        wait_rise();
        check(t_hr - s == DT_LH + 1, "R2 request to rise", t_hr - s, DT_LH + 1);
        wait_fall();
        check(t_hf - t_hr == 20, "R3 width 20", t_hf - t_hr, 20);
        wait_rise();
        check(t_hr - t_hf == MIN_OFF + DT_LH, "R4 off-time", t_hr - t_hf, MIN_OFF + DT_LH);
        check(t_lr - t_hf == DT_HL, "R6 high-to-low gap", t_lr - t_hf, DT_HL);
        check(t_hr - t_lf == DT_LH, "R5 low-to-high gap", t_hr - t_lf, DT_LH);

        // Width sweep; on_time changed while high applies to the next pulse.
        foreach (vals[i]) begin
            on_time = ON_W'(vals[i]);
            wait_fall();
            wait_rise();
            check(t_hr - t_hf == MIN_OFF + DT_LH, "R4 off-time sweep",
                  t_hr - t_hf, MIN_OFF + DT_LH);
            wait_fall();
            w = (vals[i] == 0) ? 1 : vals[i];
            check(t_hf - t_hr == w, "R3 width sweep", t_hf - t_hr, w);
        end
        on_time = 8'd20;
        wait_rise();
        fb_below = 1'b0;
        k = n_hr;
        step(300);
        check(n_hr == k, "R2 no request no pulse", n_hr - k, 0);
        check(ls_en, "R8 low held in continuous", ls_en, 1);
        zero_cross = 1'b1;
        step(100);
        check(ls_en, "R8 zero-cross ignored", ls_en, 1);
        zero_cross = 1'b0;

        // Pulse-skipping: diode emulation.
        mode = 2'd3;
        step(2);
        check(ls_en, "R7 low on before zero-cross", ls_en, 1);
        zero_cross = 1'b1;
        step(1);
        check(!ls_en, "R7 zero-cross opens low", ls_en, 0);
        zero_cross = 1'b0;
        step(100);
        check(!ls_en, "R7 low stays open", ls_en, 0);
        fb_below = 1'b1;
        wait_rise();
        fb_below = 1'b0;
        check(!ls_en, "R7 low open during pulse", ls_en, 0);
        wait_fall();
        step(DT_HL + 2);
        check(ls_en, "R7 low back after pulse", ls_en, 1);
        k = n_hr;
        step(FLOOR + 2000);
        check(n_hr == k, "R9 no forcing in pulse-skipping", n_hr - k, 0);

        // Ultrasonic floor.
        mode = 2'd2;
        wait_rise();
        wait_rise();
        r1 = t_hr;
        wait_rise();
        check(t_hr - r1 == FLOOR, "R9 forced period", t_hr - r1, FLOOR);
        wait_fall();
        step(3);
        zero_cross = 1'b1;
        step(1);
        check(!ls_en, "R7 zero-cross in ultrasonic", ls_en, 0);
        zero_cross = 1'b0;
        fb_below = 1'b1;
        wait_rise();
        fb_below = 1'b0;
        check(t_hr - t_hf == MIN_OFF + DT_LH, "R9 request earlier than floor",
              t_hr - t_hf, MIN_OFF + DT_LH);

        // Fault handling.
        mode = 2'd1;
        on_time = 8'd200;
        fb_below = 1'b1;
        wait_rise();
        step(5);
        fault_off = 1'b1;
        #1;
        check(!hs_en && !ls_en, "R10 fault drops drives at once", {hs_en, ls_en}, 0);
        step(2);
        fault_off = 1'b0;
        on_time = 8'd20;
        wait_rise();
        wait_fall();
        step(2);
        fault_off = 1'b1;
        step(2);
        fault_off = 1'b0;
        s = cyc;
        check(!ls_en, "R10 low open after fault", ls_en, 0);
        wait_rise();
        check(t_hr - s == DT_LH + 1, "R10 off-time cleared by fault", t_hr - s, DT_LH + 1);

        // Off mode.
        wait_fall();
        step(DT_HL + 2);
        mode = 2'd0;
        #1;
        check(!ls_en, "R1 off mode opens low at once", ls_en, 0);
        k = n_hr;
        step(300);
        check(n_hr == k && !hs_en && !ls_en, "R1 off mode no pulses", n_hr - k, 0);
        check(overlap == 0, "R11 no overlap", overlap, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule